// File: doc/BRIEF.md
# Fractional-Ratio Clock Enable Generator

This block turns a fast clock into a stream of one-cycle enable strobes whose long-term average rate is an exact rational fraction NUM/DEN of the clock rate. A typical use is a pixel-rate enable of about 25.175 MHz drawn from a 50 MHz clock. For that case the fraction is 1007/2000, so 1007 strobes fall in every 2000 clock cycles. Downstream logic keeps running on the fast clock and advances only in cycles where the strobe is high. No derived or gated clock is created.

A phase accumulator holds a residue in the range 0 to DEN-1. Each cycle it adds NUM. When the sum reaches DEN, the block issues a strobe and subtracts DEN from the sum. Only integer constants and integer registers are used. Because the ratio is rarely an integer, the gap between strobes alternates between the two nearest whole cycle counts. Over each full period of DEN cycles the count of strobes is exact.

Top module: `frac_clk_en`

## Requirements
- R1: While `rst_i` is sampled high at a rising edge, `strobe_o` is 0 after that edge.
- R2: After the k-th rising edge that follows reset release (k = 1, 2, ...), `strobe_o` equals floor(k*NUM/DEN) - floor((k-1)*NUM/DEN), which is either 0 or 1. As a result, the first strobe for 1007/2000 appears after edge 2, and for 3/16 after edge 6.
- R3: In every block of DEN consecutive cycles counted from reset release, exactly NUM strobes are asserted.
- R4: The distance between two consecutive strobes is always floor(DEN/NUM) or ceil(DEN/NUM) clock cycles.
- R5: Each strobe covers one clock cycle. When NUM/DEN is at most 1/2, the strobe is never high in two adjacent cycles.
- R6: A synchronous reset in a cycle where a strobe was due suppresses that strobe. It also clears the residue, so the sequence of R2 restarts with k = 1 at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast clock; all state changes on its rising edge |
| rst_i | input | 1 | Synchronous active-high reset; clears residue and strobe |
| strobe_o | output | 1 | One-cycle enable strobe at average rate NUM/DEN of `clk_i` |

## Verification
The two functions that can meet in one cycle are the synchronous reset and a strobe that the accumulator was about to raise. The bench runs its own arithmetic model until the model predicts that the next edge will fire. It then raises reset in exactly that cycle. The collision passes if the strobe stays low and the following edges reproduce the sequence from k = 1 with no leftover residue. The test runs on two ratios, one above 1/2 and one well below, so both the back-to-back case and the isolated-strobe case are covered.

// File: rtl/fce_pkg.sv
package fce_pkg;

    // Residue width: a sum of residue (< DEN) and step (< DEN) is below 2*DEN.
    function automatic int acc_width(input int den);
        return $clog2(2 * den);
    endfunction

    function automatic int ceil_div(input int a, input int b);
        return (a + b - 1) / b;
    endfunction

    function automatic int floor_div(input int a, input int b);
        return a / b;
    endfunction

    function automatic bit ratio_legal(input int num, input int den);
        return (num >= 1) && (num < den);
    endfunction

endpackage

// File: rtl/fce_wrap_calc.sv
module fce_wrap_calc
    import fce_pkg::*;
#(
    parameter int NUM = 1007,
    parameter int DEN = 2000,
    parameter int W   = acc_width(DEN)
) (
    input  logic [W-1:0] acc_i,
    output logic [W-1:0] next_o,
    output logic         fire_o
);
    localparam logic [W-1:0] STEP  = W'(NUM);
    localparam logic [W-1:0] LIMIT = W'(DEN);

    logic [W-1:0] sum;

    always_comb begin
        sum    = acc_i + STEP;
        fire_o = (sum >= LIMIT);
        next_o = fire_o ? (sum - LIMIT) : sum;
    end
endmodule

// File: rtl/fce_phase_acc.sv
module fce_phase_acc #(
    parameter int W = 12
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic [W-1:0] next_i,
    output logic [W-1:0] acc_o
);
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            acc_o <= '0;
        end else begin
            acc_o <= next_i;
        end
    end
endmodule

// File: rtl/fce_strobe_reg.sv
module fce_strobe_reg (
    input  logic clk_i,
    input  logic rst_i,
    input  logic fire_i,
    output logic strobe_o
);
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            strobe_o <= 1'b0;
        end else begin
            strobe_o <= fire_i;
        end
    end
endmodule

// File: rtl/frac_clk_en.sv
module frac_clk_en
    import fce_pkg::*;
#(
    parameter int NUM = 1007,
    parameter int DEN = 2000
) (
    input  logic clk_i,
    input  logic rst_i,
    output logic strobe_o
);
    localparam int ACC_W = acc_width(DEN);

    generate
        if (!ratio_legal(NUM, DEN)) begin : g_bad_ratio
            $error("frac_clk_en: NUM must be at least 1 and below DEN");
        end
    endgenerate

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] acc_nxt;
    logic             fire;

    fce_wrap_calc #(
        .NUM (NUM),
        .DEN (DEN),
        .W   (ACC_W)
    ) wrap_i (
        .acc_i  (acc_q),
        .next_o (acc_nxt),
        .fire_o (fire)
    );

    fce_phase_acc #(
        .W (ACC_W)
    ) phase_i (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .next_i (acc_nxt),
        .acc_o  (acc_q)
    );

    fce_strobe_reg strobe_i (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .fire_i   (fire),
        .strobe_o (strobe_o)
    );
endmodule

// File: rtl/fce_checker.sv
module fce_checker
    import fce_pkg::*;
#(
    parameter int NUM = 1007,
    parameter int DEN = 2000,
    parameter int W   = acc_width(DEN)
) (
    input logic         clk,
    input logic         rst,
    input logic         strobe,
    input logic [W-1:0] acc
);
    localparam int MAXG = ceil_div(DEN, NUM);
    localparam int MING = floor_div(DEN, NUM);

    logic [1:0]   hist_q = 2'd0;
    logic [W-1:0] gap_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q <= 2'd1;
        end else if (hist_q != 2'd0 && hist_q != 2'd3) begin
            hist_q <= hist_q + 2'd1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || strobe) begin
            gap_q <= '0;
        end else begin
            gap_q <= gap_q + 1'b1;
        end
    end

    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> !strobe);

    // R6: reset leaves no residue behind
    assert_acc_clear_R6: assert property (@(posedge clk)
        rst |=> (acc == '0));

    assert_acc_range_R2: assert property (@(posedge clk) disable iff (rst)
        (hist_q >= 2'd2) |-> (int'(acc) < DEN));

    assert_acc_step_R2: assert property (@(posedge clk) disable iff (rst)
        (hist_q >= 2'd2) |->
            (int'(acc) == (strobe ? int'($past(acc)) + NUM - DEN
                                  : int'($past(acc)) + NUM)));

    assert_max_gap_R4: assert property (@(posedge clk) disable iff (rst)
        (hist_q >= 2'd2) |-> (int'(gap_q) <= MAXG));

    generate
        if (MING >= 2) begin : g_sparse
            assert_no_double_R5: assert property (@(posedge clk) disable iff (rst)
                strobe |=> !strobe);
        end
    endgenerate
endmodule

bind frac_clk_en fce_checker #(
    .NUM (NUM),
    .DEN (DEN),
    .W   (ACC_W)
) chk_i (
    .clk    (clk_i),
    .rst    (rst_i),
    .strobe (strobe_o),
    .acc    (acc_q)
);

// File: tb/frac_clk_en_tb_top.sv
`timescale 1ns/1ps
module frac_clk_en_tb_top;

    localparam longint AN = 1007;
    localparam longint AD = 2000;
    localparam longint BN = 3;
    localparam longint BD = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic stb_a;
    logic stb_b;

    always #2.5 clk = ~clk;

    frac_clk_en #(.NUM(1007), .DEN(2000)) dut_i (
        .clk_i (clk), .rst_i (rst), .strobe_o (stb_a));

    frac_clk_en #(.NUM(3), .DEN(16)) dut_b_i (
        .clk_i (clk), .rst_i (rst), .strobe_o (stb_b));

    int  errors = 0;
    int  checks = 0;
    bit  done   = 1'b0;
    bit  cmp_on = 1'b0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    function automatic bit fires(input longint k, input longint n, input longint d);
        return ((k * n) / d) != (((k - 1) * n) / d);
    endfunction

    // Reference model: edge index since reset release and predicted strobe
    longint ka = 0, kb = 0;
    bit     exp_a = 1'b0, exp_b = 1'b0;

    always @(posedge clk) begin
        if (rst) begin
            ka <= 0; kb <= 0; exp_a <= 1'b0; exp_b <= 1'b0;
        end else begin
            ka <= ka + 1; kb <= kb + 1;
            exp_a <= fires(ka + 1, AN, AD);
            exp_b <= fires(kb + 1, BN, BD);
        end
    end

    // Per-cycle comparison, spacing and window counts
    longint win_a = 0, win_b = 0;
    longint cyc = 0, last_a = 0, last_b = 0;
    bit     seen_a = 1'b0, seen_b = 1'b0;

    always @(negedge clk) begin
        if (cmp_on) begin
            chk(stb_a == exp_a, "R2 seq 1007/2000", stb_a, exp_a);
            chk(stb_b == exp_b, "R2 seq 3/16", stb_b, exp_b);
            if (rst) begin
                win_a = 0; win_b = 0; seen_a = 1'b0; seen_b = 1'b0; cyc = 0;
            end else begin
                cyc++;
                if (stb_a) begin
                    win_a++;
                    if (seen_a)
                        chk((cyc - last_a == 1) || (cyc - last_a == 2), "R4 gap 1007/2000", cyc - last_a, 2);
                    seen_a = 1'b1; last_a = cyc;
                end
                if (stb_b) begin
                    win_b++;
                    if (seen_b)
                        chk((cyc - last_b == 5) || (cyc - last_b == 6), "R4 R5 gap 3/16", cyc - last_b, 6);
                    seen_b = 1'b1; last_b = cyc;
                end
                if (ka != 0 && ka % AD == 0) begin
                    chk(win_a == AN, "R3 window 1007/2000", win_a, AN);
                    win_a = 0;
                end
                if (kb != 0 && kb % BD == 0) begin
                    chk(win_b == BN, "R3 window 3/16", win_b, BN);
                    win_b = 0;
                end
            end
        end
    end

    initial begin
        @(negedge clk);
        cmp_on = 1'b1;
        repeat (3) @(negedge clk);
        chk(stb_a == 1'b0, "R1 reset 1007/2000", stb_a, 0);
        chk(stb_b == 1'b0, "R1 reset 3/16", stb_b, 0);
        rst = 1'b0;

        // First strobes: edge 2 for A, edge 6 for B
        @(negedge clk);
        chk(stb_a == 1'b0, "R2 edge1 1007/2000", stb_a, 0);
        @(negedge clk);
        chk(stb_a == 1'b1, "R2 edge2 1007/2000", stb_a, 1);
        repeat (3) @(negedge clk);
        chk(stb_b == 1'b0, "R2 edge5 3/16", stb_b, 0);
        @(negedge clk);
        chk(stb_b == 1'b1, "R2 edge6 3/16", stb_b, 1);

        repeat (2100) @(negedge clk);

        // R6: reset lands on a cycle where A is due to fire
        while (!fires(ka + 1, AN, AD)) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk(stb_a == 1'b0, "R6 collision 1007/2000", stb_a, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(stb_a == 1'b0, "R6 restart edge1", stb_a, 0);
        @(negedge clk);
        chk(stb_a == 1'b1, "R6 restart edge2", stb_a, 1);

        // Mid-run reset held for two cycles on B's schedule
        repeat (37) @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk(stb_b == 1'b0, "R1 midrun 3/16", stb_b, 0);
        rst = 1'b0;
        repeat (2050) @(negedge clk);

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R2 watchdog actual=timeout expected=completion");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule